// File: doc/BRIEF.md
# Serialized Peripheral Reset Controller

This block keeps one reset control word per partition, with one bit for each peripheral reset domain. It also presents a status word per partition. Each status word mirrors the reset-acknowledge inputs that come back from the domains. Software writes a new control value over a simple register bus. The block does not apply that value in one go. It finds the bits that differ from the value currently applied and walks through them one at a time, starting with the lowest index. For each bit it moves the reset line, then waits until that domain's acknowledge shows the new state before it touches the next bit. As a result, no two domains ever enter or leave reset in the same cycle.

Each wait is bounded by a programmable cycle limit. If a domain never confirms, the block raises a sticky error, abandons the bits it has not yet applied and returns to idle. While a sequence runs, a busy flag is set and further control writes are dropped. They are never merged into the sequence in progress. The register bus has no stream data, so it is a plain single-cycle write strobe with a combinational read port and no back-pressure.

Top module: `seq_rst_ctrl`

## Requirements
- R1: After reset every control bit is 1, so every reset output is asserted. The busy flag reads 0, the error flag reads 0 and the timeout limit reads 255.
- R2: The control word of partition N is at byte address 0x40 + 8*N and reads back the currently applied value. The status word of partition N is at 0x140 + 8*N and reads the acknowledge inputs of that partition, where 1 means the domain is still in reset.
- R3: Reset output bit b of partition N is `dom_rst_o[N*DOM_W+b]` and always equals control bit b of that partition. A 1 holds the domain in reset.
- R4: The bits to change are the XOR of the applied word and the written word. They are applied one per step in ascending index order, and at most one reset output changes in any cycle.
- R5: After a bit is applied, the next bit changes only once that domain's acknowledge input equals the new value.
- R6: The flags word at 0x004 has busy in bit 0. Busy reads 1 from the cycle after an accepted control write until the last step completes. A control write that arrives while busy is ignored.
- R7: A control write that changes no bit never raises busy.
- R8: The timeout limit is at 0x000. If a wait lasts past the limit, bit 1 of the flags word (the error flag) sets and stays set, busy drops, and the bits not yet applied keep their old value.
- R9: Writing the flags word with bit 1 set clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte address for both write and read |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| dom_ack_i | input | NUM_PART*DOM_W | Per-domain acknowledge, 1 while the domain is in reset |
| dom_rst_o | output | NUM_PART*DOM_W | Per-domain reset, 1 holds the domain in reset |
| busy_o | output | 1 | A serialized update is in progress |
| err_o | output | 1 | Sticky timeout error |

## Verification
The bench watches the reset outputs every cycle. A design that applied the whole XOR at once would show two outputs changing together. A design that scanned from the top bit downward would show a descending index. A design that skipped the acknowledge wait would move the next bit while the previous domain still disagreed. A stuck domain is used to check the timeout path: a design that kept going after the timeout would leave the later bits applied, and one that cleared the error on its own would read 0. A second write is issued during a running sequence, and a no-change write is issued while idle. A design that merged the second write would alter the other partition, and one that entered busy for a no-change write would show busy.

// File: rtl/seq_rst_pkg.sv
package seq_rst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/lsb_pick.sv
module lsb_pick #(
  parameter int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  onehot_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
    onehot_o = valid_o ? (W'(1) << idx_o) : '0;
  end

  always_comb begin
    assert_pick_onehot_R4: assert ($onehot0(onehot_o));
  end
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (!run_i)                 cnt_q <= '0;
    else if (cnt_q != {TMO_W{1'b1}}) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q >= limit_i);
endmodule

// File: rtl/seq_rst_ctrl.sv
module seq_rst_ctrl
  import seq_rst_pkg::*;
#(
  parameter int NUM_PART = 2,
  parameter int DOM_W    = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  parameter int TMO_W    = 16,
  parameter int TMO_RST  = 255
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr_en,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  input  logic [NUM_PART*DOM_W-1:0] dom_ack_i,
  output logic [NUM_PART*DOM_W-1:0] dom_rst_o,
  output logic                      busy_o,
  output logic                      err_o
);
  localparam int PART_W    = (NUM_PART > 1) ? $clog2(NUM_PART) : 1;
  localparam int IDX_W     = (DOM_W > 1) ? $clog2(DOM_W) : 1;
  localparam int CTRL_BASE = 'h40;
  localparam int STAT_BASE = 'h140;
  localparam int STRIDE    = 8;
  localparam logic [ADDR_W-1:0] TMO_ADDR  = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'('h004);

  seq_state_e         state_q;
  logic [DOM_W-1:0]   ctrl_q [NUM_PART];
  logic [DOM_W-1:0]   ack_arr [NUM_PART];
  logic [DOM_W-1:0]   tgt_q, pend_q;
  logic [PART_W-1:0]  part_q;
  logic [IDX_W-1:0]   idx_q;
  logic               err_q;
  logic [TMO_W-1:0]   tmo_q;

  logic               ctrl_hit, stat_hit;
  logic [PART_W-1:0]  ctrl_sel, stat_sel;
  logic [DOM_W-1:0]   wr_diff;
  logic               start;
  logic               pick_vld;
  logic [IDX_W-1:0]   pick_idx;
  logic [DOM_W-1:0]   pick_oh;
  logic               tmo_hit;
  logic               ack_ok;

  for (genvar p = 0; p < NUM_PART; p++) begin : g_part
    assign ack_arr[p]                     = dom_ack_i[p*DOM_W +: DOM_W];
    assign dom_rst_o[p*DOM_W +: DOM_W]    = ctrl_q[p];
  end

  always_comb begin
    ctrl_hit = 1'b0;
    stat_hit = 1'b0;
    ctrl_sel = '0;
    stat_sel = '0;
    for (int p = 0; p < NUM_PART; p++) begin
      if (reg_addr == ADDR_W'(CTRL_BASE + STRIDE * p)) begin
        ctrl_hit = 1'b1;
        ctrl_sel = PART_W'(p);
      end
      if (reg_addr == ADDR_W'(STAT_BASE + STRIDE * p)) begin
        stat_hit = 1'b1;
        stat_sel = PART_W'(p);
      end
    end
  end

  assign wr_diff = ctrl_q[ctrl_sel] ^ reg_wdata[DOM_W-1:0];
  assign start   = reg_wr_en && ctrl_hit && (state_q == ST_IDLE) && (wr_diff != '0);
  assign ack_ok  = (ack_arr[part_q][idx_q] == tgt_q[idx_q]);
  assign busy_o  = (state_q != ST_IDLE);
  assign err_o   = err_q;

  lsb_pick #(.W(DOM_W)) u_pick (
    .vec_i   (pend_q),
    .valid_o (pick_vld),
    .idx_o   (pick_idx),
    .onehot_o(pick_oh)
  );

  wait_timer #(.TMO_W(TMO_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (state_q == ST_WAIT),
    .limit_i  (tmo_q),
    .expired_o(tmo_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      for (int p = 0; p < NUM_PART; p++) ctrl_q[p] <= '1;
      tgt_q   <= '0;
      pend_q  <= '0;
      part_q  <= '0;
      idx_q   <= '0;
      err_q   <= 1'b0;
      tmo_q   <= TMO_W'(TMO_RST);
    end else begin
      if (reg_wr_en && reg_addr == TMO_ADDR)               tmo_q <= reg_wdata[TMO_W-1:0];
      if (reg_wr_en && reg_addr == FLAG_ADDR && reg_wdata[1]) err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            tgt_q   <= reg_wdata[DOM_W-1:0];
            pend_q  <= wr_diff;
            part_q  <= ctrl_sel;
            state_q <= ST_STEP;
          end
        end
        ST_STEP: begin
          if (pick_vld) begin
            ctrl_q[part_q][pick_idx] <= tgt_q[pick_idx];
            idx_q   <= pick_idx;
            state_q <= ST_WAIT;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (ack_ok) begin
            pend_q  <= pend_q & ~pick_oh;
            state_q <= ((pend_q & ~pick_oh) == '0) ? ST_IDLE : ST_STEP;
          end else if (tmo_hit) begin
            err_q   <= 1'b1;
            pend_q  <= '0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (ctrl_hit)                    reg_rdata[DOM_W-1:0] = ctrl_q[ctrl_sel];
    else if (stat_hit)               reg_rdata[DOM_W-1:0] = ack_arr[stat_sel];
    else if (reg_addr == FLAG_ADDR)  reg_rdata[1:0]       = {err_q, busy_o};
    else if (reg_addr == TMO_ADDR)   reg_rdata[TMO_W-1:0] = tmo_q;
  end

  assert_one_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dom_rst_o ^ $past(dom_rst_o)) <= 1);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(dom_rst_o));

  assert_wait_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !ack_ok) |=> $stable(dom_rst_o));

  assert_noop_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && ctrl_hit && !busy_o && wr_diff == '0) |=> !busy_o);

  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !busy_o);
endmodule

// File: tb/seq_rst_ctrl_bench.sv
module seq_rst_ctrl_bench;
  localparam int NP = 2;
  localparam int DW = 8;
  localparam int FW = NP * DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [FW-1:0] dom_ack = '1;
  logic [FW-1:0] dom_rst;
  logic          busy, err;

  int            n_chk = 0, n_fail = 0;
  int            lag = 2;
  logic [FW-1:0] stuck = '0;
  int            cnt [FW];
  logic [DW-1:0] exp_ctrl [NP];
  logic [FW-1:0] prev_rst;
  int            mon_last = -1;
  int            cyc = 0;

  always #4 clk = ~clk;

  seq_rst_ctrl u_seq_rst_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dom_ack_i(dom_ack),
    .dom_rst_o(dom_rst), .busy_o(busy), .err_o(err)
  );

  // Domain model: acknowledge follows the reset line after `lag` cycles.
  always @(posedge clk) begin
    for (int b = 0; b < FW; b++) begin
      if (!rst_n) begin
        dom_ack[b] <= 1'b1; cnt[b] <= 0;
      end else if (dom_ack[b] != dom_rst[b] && !stuck[b]) begin
        if (cnt[b] + 1 >= lag) begin dom_ack[b] <= dom_rst[b]; cnt[b] <= 0; end
        else cnt[b] <= cnt[b] + 1;
      end else cnt[b] <= 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Per-cycle monitor of the reset outputs.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      logic [FW-1:0] d;
      d = dom_rst ^ prev_rst;
      if (d != '0) begin
        int j;
        j = 0;
        for (int b = FW - 1; b >= 0; b--) if (d[b]) j = b;
        chk($countones(d) == 1, "R4 one output per cycle", 32'(d), 32'(1 << j));
        if (mon_last >= 0) begin
          chk(j > mon_last, "R4 ascending order", j, mon_last + 1);
          chk(dom_ack[mon_last] == dom_rst[mon_last], "R5 previous bit acknowledged",
              32'(dom_ack[mon_last]), 32'(dom_rst[mon_last]));
        end
        mon_last = j;
      end
    end
    prev_rst = dom_rst;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL R6 watchdog expired actual=busy expected=idle");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (lag + 3) @(negedge clk);
  endtask

  task automatic check_part(input int p, input string tag);
    logic [31:0] r;
    rd(12'(32'h40 + 8 * p), r);
    chk(r[DW-1:0] == exp_ctrl[p], {tag, " R2 control readback"}, r, 32'(exp_ctrl[p]));
    chk(dom_rst[p*DW +: DW] == exp_ctrl[p], {tag, " R3 outputs match control"},
        32'(dom_rst[p*DW +: DW]), 32'(exp_ctrl[p]));
    rd(12'(32'h140 + 8 * p), r);
    chk(r[DW-1:0] == dom_ack[p*DW +: DW], {tag, " R2 status readback"}, r, 32'(dom_ack[p*DW +: DW]));
  endtask

  initial begin
    logic [31:0] r;
    logic [DW-1:0] v, old;
    void'($urandom(32'd1234));
    prev_rst = '1;
    for (int p = 0; p < NP; p++) exp_ctrl[p] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(dom_rst == '1, "R1 outputs in reset", 32'(dom_rst), 32'(FW'('1)));
    rd(12'h004, r); chk(r == 0, "R1 flags clear", r, 0);
    rd(12'h000, r); chk(r == 255, "R1 timeout default", r, 255);
    for (int p = 0; p < NP; p++) check_part(p, "R1");

    wr(12'h000, 32'd20);

    // R7 no-change write
    mon_last = -1;
    wr(12'h40, 32'(exp_ctrl[0]));
    chk(!busy, "R7 no busy on unchanged write", 32'(busy), 0);

    // Random sequences
    for (int it = 0; it < 40; it++) begin
      int p;
      p   = $urandom_range(NP - 1);
      v   = DW'($urandom);
      lag = $urandom_range(4, 1);
      mon_last = -1;
      wr(12'(32'h40 + 8 * p), 32'(v));
      if (v != exp_ctrl[p]) begin
        rd(12'h004, r); chk(r[0] == 1'b1, "R6 busy after change", r, 1);
      end else begin
        chk(!busy, "R7 no busy on unchanged write", 32'(busy), 0);
      end
      exp_ctrl[p] = v;
      wait_idle();
      check_part(p, "rand");
      chk(!err, "R8 no error when acknowledged in time", 32'(err), 0);
    end

    // R6 write while busy is dropped
    lag = 4; mon_last = -1;
    v = exp_ctrl[0] ^ 8'hF3;
    old = exp_ctrl[1];
    wr(12'h40, 32'(v));
    wr(12'h48, 32'(~old));
    chk(busy, "R6 busy during sequence", 32'(busy), 1);
    exp_ctrl[0] = v;
    wait_idle();
    check_part(0, "R6");
    check_part(1, "R6 second write ignored");

    // R8 timeout abort with a stuck domain at bit 2
    lag = 2; mon_last = -1;
    wr(12'h000, 32'd10);
    stuck = FW'(1) << 2;
    old = exp_ctrl[0];
    wr(12'h40, 32'(old ^ 8'b0010_0110));
    wait_idle();
    rd(12'h004, r); chk(r[1:0] == 2'b10, "R8 error set, busy clear", r, 2);
    exp_ctrl[0] = old ^ 8'b0000_0110;
    rd(12'h40, r); chk(r[DW-1:0] == exp_ctrl[0], "R8 later bits not applied", r, 32'(exp_ctrl[0]));
    repeat (20) @(negedge clk);
    rd(12'h004, r); chk(r[1] == 1'b1, "R8 error sticky", r, 2);

    // R9 clear error
    stuck = '0;
    wr(12'h004, 32'h2);
    rd(12'h004, r); chk(r[1] == 1'b0, "R9 error cleared", r, 0);
    repeat (6) @(negedge clk);
    check_part(0, "R9");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule